// File: doc/BRIEF.md
# Fixed-Point Dot-Product Accelerator

This block computes a single dot product between a row of weights and a vector of input activations, where both vectors sit in external memory. Every operand and the result is a 32-bit signed number in Q16.16 format, so one least significant bit stands for 1/65536. Software fills three configuration words through a memory-mapped slave port: the byte address of the first weight, the byte address of the first activation and the element count. It then writes the control word to launch the job.

A bus master port reads each weight and its matching activation in turn, one request outstanding at a time. The block multiplies each pair and rescales the 64-bit product back to Q16.16. It adds the rescaled product to a 32-bit accumulator that wraps. At the end it can clamp a negative total to zero, which is a rectified linear stage selected per job. Software collects the value by reading the control word. That read stalls through waitrequest until the job has finished, so one read both waits for the job and returns its answer.

Top module: `dotacc_top`

## Requirements
- R1: After reset, a read of word offset 0 returns 0 with no waitrequest cycle, and word offsets 2, 3 and 5 read back 0.
- R2: Word offset 2 holds the weight base byte address, offset 3 holds the activation base byte address and offset 5 holds the element count in its low LW bits. Each reads back what was last written, and offsets 1, 4, 6 and 7 read as 0.
- R3: A write to word offset 0 starts a job. Element i of each vector is read from base + 4*i. For each element the weight word is requested before the activation word, and the master never has more than one read outstanding.
- R4: Each term is bits [47:16] of the 64-bit signed product of weight and activation, which rounds toward minus infinity. The result is the sum of these terms.
- R5: A read of word offset 0 holds s_waitrequest high while a job is pending, then returns the result. s_waitrequest is never high for any other access.
- R6: Bit 0 of the start write selects the rectified stage. With bit 0 set, a negative total returns 0. With bit 0 clear, the total is returned unchanged.
- R7: A job with an element count of 0 finishes two cycles after the start pulse, with a result of 0.
- R8: The accumulator wraps modulo 2^32 and is cleared at every start, so back-to-back jobs do not carry sums from one to the next.
- R9: While m_waitrequest is high, the master keeps m_read and m_addr unchanged. It takes m_readdata only in cycles with m_readdatavalid high, so the result does not depend on stall or latency.
- R10: While a job is pending, writes to word offset 0 are ignored. Writes to offsets 2, 3 and 5 update the registers but do not change the running job.
- R11: The value returned at offset 0 stays stable from the end of a job until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_addr | input | SAW (3) | Slave word offset |
| s_write | input | 1 | Slave write strobe |
| s_writedata | input | DW (32) | Slave write data |
| s_read | input | 1 | Slave read strobe |
| s_readdata | output | DW (32) | Slave read data |
| s_waitrequest | output | 1 | Slave stall, raised only for a read of offset 0 during a job |
| m_addr | output | AW (32) | Master read byte address |
| m_read | output | 1 | Master read request |
| m_waitrequest | input | 1 | Memory not ready to accept the request |
| m_readdata | input | DW (32) | Memory read data |
| m_readdatavalid | input | 1 | m_readdata holds a response |

## Verification
The hardest case to reach from the ports is a control-register write that arrives while a job is still running, because a job normally finishes in a few cycles. The bench's memory model is therefore set to several cycles of waitrequest and a long response latency, which holds the job open. During that window the bench rewrites the configuration and issues a second start with the rectified stage selected. It then checks that the result still matches the first job's negative sum and that the rewritten registers read back. The same memory model drives filler values on m_readdata between responses, so data taken in the wrong cycle would corrupt the sum.

// File: rtl/dotacc_pkg.sv
package dotacc_pkg;

    // Slave word offsets; software depends on these positions.
    localparam int OFF_CTRL  = 0;
    localparam int OFF_WBASE = 2;
    localparam int OFF_ABASE = 3;
    localparam int OFF_LEN   = 5;

    // Bytes per operand word.
    localparam int WORD_BYTES = 4;

    typedef enum logic [2:0] {
        F_IDLE,
        F_REQ_W,
        F_WAIT_W,
        F_REQ_A,
        F_WAIT_A
    } fetch_st_e;

endpackage

// File: rtl/dotacc_regs.sv
module dotacc_regs
    import dotacc_pkg::*;
#(
    parameter int DW  = 32,
    parameter int AW  = 32,
    parameter int LW  = 16,
    parameter int SAW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [SAW-1:0] s_addr,
    input  logic           s_write,
    input  logic [DW-1:0]  s_writedata,
    input  logic           s_read,
    output logic [DW-1:0]  s_readdata,
    output logic           s_waitrequest,
    input  logic           busy,
    input  logic [DW-1:0]  result,
    output logic           start,
    output logic           relu_sel,
    output logic [AW-1:0]  wbase,
    output logic [AW-1:0]  abase,
    output logic [LW-1:0]  len
);

    localparam logic [SAW-1:0] A_CTRL  = SAW'(OFF_CTRL);
    localparam logic [SAW-1:0] A_WBASE = SAW'(OFF_WBASE);
    localparam logic [SAW-1:0] A_ABASE = SAW'(OFF_ABASE);
    localparam logic [SAW-1:0] A_LEN   = SAW'(OFF_LEN);

    typedef struct packed {
        logic [AW-1:0] wbase;
        logic [AW-1:0] abase;
        logic [LW-1:0] len;
        logic          start;
        logic          relu;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d       = q;
        d.start = 1'b0;
        if (s_write) begin
            if (s_addr == A_CTRL) begin
                // A start while a job is pending is dropped.
                if (!busy) begin
                    d.start = 1'b1;
                    d.relu  = s_writedata[0];
                end
            end else if (s_addr == A_WBASE) begin
                d.wbase = AW'(s_writedata);
            end else if (s_addr == A_ABASE) begin
                d.abase = AW'(s_writedata);
            end else if (s_addr == A_LEN) begin
                d.len = s_writedata[LW-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        s_readdata = '0;
        if (s_addr == A_CTRL) begin
            s_readdata = result;
        end else if (s_addr == A_WBASE) begin
            s_readdata = DW'(q.wbase);
        end else if (s_addr == A_ABASE) begin
            s_readdata = DW'(q.abase);
        end else if (s_addr == A_LEN) begin
            s_readdata = DW'(q.len);
        end
    end

    assign s_waitrequest = s_read && (s_addr == A_CTRL) && busy;
    assign start         = q.start;
    assign relu_sel      = q.relu;
    assign wbase         = q.wbase;
    assign abase         = q.abase;
    assign len           = q.len;

endmodule

// File: rtl/dotacc_fetch.sv
module dotacc_fetch
    import dotacc_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 32,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] wbase,
    input  logic [AW-1:0] abase,
    input  logic [LW-1:0] len,
    output logic          m_read,
    output logic [AW-1:0] m_addr,
    input  logic          m_waitrequest,
    input  logic [DW-1:0] m_readdata,
    input  logic          m_readdatavalid,
    output logic          pair_vld,
    output logic          pair_last,
    output logic [DW-1:0] pair_w,
    output logic [DW-1:0] pair_a,
    output logic          empty_done
);

    localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

    typedef struct packed {
        fetch_st_e     st;
        logic [AW-1:0] wptr;
        logic [AW-1:0] aptr;
        logic [LW-1:0] remain;
        logic [DW-1:0] wbuf;
        logic          pvld;
        logic          plast;
        logic [DW-1:0] pw;
        logic [DW-1:0] pa;
        logic          empty;
    } fetch_t;

    fetch_t q, d;

    always_comb begin
        d       = q;
        d.pvld  = 1'b0;
        d.plast = 1'b0;
        d.empty = 1'b0;
        unique case (q.st)
            F_IDLE: begin
                if (start) begin
                    if (len == '0) begin
                        d.empty = 1'b1;
                    end else begin
                        d.wptr   = wbase;
                        d.aptr   = abase;
                        d.remain = len;
                        d.st     = F_REQ_W;
                    end
                end
            end
            F_REQ_W: begin
                if (!m_waitrequest) d.st = F_WAIT_W;
            end
            F_WAIT_W: begin
                if (m_readdatavalid) begin
                    d.wbuf = m_readdata;
                    d.st   = F_REQ_A;
                end
            end
            F_REQ_A: begin
                if (!m_waitrequest) d.st = F_WAIT_A;
            end
            F_WAIT_A: begin
                if (m_readdatavalid) begin
                    d.pvld   = 1'b1;
                    d.pw     = q.wbuf;
                    d.pa     = m_readdata;
                    d.plast  = (q.remain == LW'(1));
                    d.remain = q.remain - LW'(1);
                    d.wptr   = q.wptr + STEP;
                    d.aptr   = q.aptr + STEP;
                    d.st     = (q.remain == LW'(1)) ? F_IDLE : F_REQ_W;
                end
            end
            default: d.st = F_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= F_IDLE;
        end else begin
            q <= d;
        end
    end

    assign m_read     = (q.st == F_REQ_W) || (q.st == F_REQ_A);
    assign m_addr     = (q.st == F_REQ_A) ? q.aptr : q.wptr;
    assign pair_vld   = q.pvld;
    assign pair_last  = q.plast;
    assign pair_w     = q.pw;
    assign pair_a     = q.pa;
    assign empty_done = q.empty;

endmodule

// File: rtl/dotacc_mac.sv
module dotacc_mac #(
    parameter int DW   = 32,
    parameter int FRAC = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          relu_in,
    input  logic          pair_vld,
    input  logic          pair_last,
    input  logic [DW-1:0] pair_w,
    input  logic [DW-1:0] pair_a,
    input  logic          empty_done,
    output logic [DW-1:0] result,
    output logic          done
);

    typedef struct packed {
        logic [DW-1:0] acc;
        logic [DW-1:0] res;
        logic          done;
        logic          relu;
    } mac_t;

    mac_t q, d;

    logic signed [2*DW-1:0] prod;
    logic        [DW-1:0]   term;
    logic        [DW-1:0]   sum;

    always_comb begin
        prod = $signed(pair_w) * $signed(pair_a);
        term = DW'(prod >>> FRAC);
        sum  = q.acc + term;
    end

    always_comb begin
        d = q;
        if (start) begin
            d.acc  = '0;
            d.done = 1'b0;
            d.relu = relu_in;
        end
        if (empty_done) begin
            d.res  = '0;
            d.done = 1'b1;
        end
        if (pair_vld) begin
            d.acc = sum;
            if (pair_last) begin
                d.res  = (q.relu && sum[DW-1]) ? '0 : sum;
                d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.done <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign result = q.res;
    assign done   = q.done;

endmodule

// File: rtl/dotacc_top.sv
module dotacc_top #(
    parameter int DW   = 32,
    parameter int AW   = 32,
    parameter int LW   = 16,
    parameter int SAW  = 3,
    parameter int FRAC = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [SAW-1:0] s_addr,
    input  logic           s_write,
    input  logic [DW-1:0]  s_writedata,
    input  logic           s_read,
    output logic [DW-1:0]  s_readdata,
    output logic           s_waitrequest,
    output logic [AW-1:0]  m_addr,
    output logic           m_read,
    input  logic           m_waitrequest,
    input  logic [DW-1:0]  m_readdata,
    input  logic           m_readdatavalid
);

    logic          start_w;
    logic          relu_w;
    logic [AW-1:0] wbase_w;
    logic [AW-1:0] abase_w;
    logic [LW-1:0] len_w;
    logic          busy_w;
    logic          done_w;
    logic [DW-1:0] result_w;
    logic          pvld_w;
    logic          plast_w;
    logic [DW-1:0] pw_w;
    logic [DW-1:0] pa_w;
    logic          empty_w;

    // Pending covers the start-pulse cycle, before the MAC drops done.
    assign busy_w = start_w || !done_w;

    dotacc_regs #(.DW(DW), .AW(AW), .LW(LW), .SAW(SAW)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .s_addr       (s_addr),
        .s_write      (s_write),
        .s_writedata  (s_writedata),
        .s_read       (s_read),
        .s_readdata   (s_readdata),
        .s_waitrequest(s_waitrequest),
        .busy         (busy_w),
        .result       (result_w),
        .start        (start_w),
        .relu_sel     (relu_w),
        .wbase        (wbase_w),
        .abase        (abase_w),
        .len          (len_w)
    );

    dotacc_fetch #(.DW(DW), .AW(AW), .LW(LW)) u_fetch (
        .clk            (clk),
        .rst_n          (rst_n),
        .start          (start_w),
        .wbase          (wbase_w),
        .abase          (abase_w),
        .len            (len_w),
        .m_read         (m_read),
        .m_addr         (m_addr),
        .m_waitrequest  (m_waitrequest),
        .m_readdata     (m_readdata),
        .m_readdatavalid(m_readdatavalid),
        .pair_vld       (pvld_w),
        .pair_last      (plast_w),
        .pair_w         (pw_w),
        .pair_a         (pa_w),
        .empty_done     (empty_w)
    );

    dotacc_mac #(.DW(DW), .FRAC(FRAC)) u_mac (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start_w),
        .relu_in   (relu_w),
        .pair_vld  (pvld_w),
        .pair_last (plast_w),
        .pair_w    (pw_w),
        .pair_a    (pa_w),
        .empty_done(empty_w),
        .result    (result_w),
        .done      (done_w)
    );

endmodule

// File: rtl/dotacc_chk.sv
module dotacc_chk #(
    parameter int DW  = 32,
    parameter int AW  = 32,
    parameter int LW  = 16,
    parameter int SAW = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic [SAW-1:0] s_addr,
    input logic           s_read,
    input logic           s_write,
    input logic           s_waitrequest,
    input logic           m_read,
    input logic [AW-1:0]  m_addr,
    input logic           m_waitrequest,
    input logic           m_readdatavalid,
    input logic           start_w,
    input logic           done_w,
    input logic [LW-1:0]  len_w,
    input logic [DW-1:0]  result_w
);

    logic [1:0] outst;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outst <= '0;
        end else begin
            outst <= outst + 2'((m_read && !m_waitrequest) ? 1 : 0)
                           - 2'(m_readdatavalid ? 1 : 0);
        end
    end

    assert_one_outstanding_R3: assert property (@(posedge clk) disable iff (!rst_n)
        m_read |-> (outst == 2'd0));

    assert_req_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (m_read && m_waitrequest) |=> (m_read && $stable(m_addr)));

    assert_wait_only_ctrl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        s_waitrequest |-> (s_read && s_addr == '0));

    assert_empty_job_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_w && len_w == '0) |=> ##1 (done_w && result_w == '0));

    assert_busy_start_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (s_write && s_addr == '0 && (start_w || !done_w)) |=> !start_w);

    assert_result_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (done_w && !start_w) |=> $stable(result_w));

endmodule

bind dotacc_top dotacc_chk #(.DW(DW), .AW(AW), .LW(LW), .SAW(SAW)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .s_addr         (s_addr),
    .s_read         (s_read),
    .s_write        (s_write),
    .s_waitrequest  (s_waitrequest),
    .m_read         (m_read),
    .m_addr         (m_addr),
    .m_waitrequest  (m_waitrequest),
    .m_readdatavalid(m_readdatavalid),
    .start_w        (start_w),
    .done_w         (done_w),
    .len_w          (len_w),
    .result_w       (result_w)
);

// File: tb/dotacc_top_tb.sv
module dotacc_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  s_addr = '0;
    logic        s_write = 1'b0;
    logic [31:0] s_writedata = '0;
    logic        s_read = 1'b0;
    logic [31:0] s_readdata;
    logic        s_waitrequest;
    logic [31:0] m_addr;
    logic        m_read;
    logic        m_waitrequest;
    logic [31:0] m_readdata;
    logic        m_readdatavalid;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    dotacc_top u_dut (
        .clk(clk), .rst_n(rst_n),
        .s_addr(s_addr), .s_write(s_write), .s_writedata(s_writedata),
        .s_read(s_read), .s_readdata(s_readdata), .s_waitrequest(s_waitrequest),
        .m_addr(m_addr), .m_read(m_read), .m_waitrequest(m_waitrequest),
        .m_readdata(m_readdata), .m_readdatavalid(m_readdatavalid)
    );

    // ---------------- memory model ----------------
    logic [31:0] mem [256];
    int          stall_cfg = 0;
    int          lat_cfg   = 1;
    int          wait_cnt  = 0;
    logic        pend      = 1'b0;
    logic [31:0] paddr     = '0;
    int          lcnt      = 0;
    logic [31:0] log_addr [8];
    int          log_n     = 0;

    assign m_waitrequest = m_read && (wait_cnt < stall_cfg);

    always @(posedge clk) begin
        m_readdatavalid <= 1'b0;
        m_readdata      <= 32'hA5A5_A5A5;
        if (m_read && !m_waitrequest) begin
            wait_cnt <= 0;
            pend     <= 1'b1;
            paddr    <= m_addr;
            lcnt     <= lat_cfg;
            if (log_n < 8) log_addr[log_n] <= m_addr;
            log_n <= log_n + 1;
        end else if (m_read) begin
            wait_cnt <= wait_cnt + 1;
        end
        if (pend) begin
            if (lcnt <= 1) begin
                m_readdatavalid <= 1'b1;
                m_readdata      <= mem[paddr[9:2]];
                pend            <= 1'b0;
            end else begin
                lcnt <= lcnt - 1;
            end
        end
    end

    // ---------------- helpers ----------------
    function automatic logic [31:0] model(int wb, int ab, int n, bit relu);
        logic [31:0] acc = '0;
        for (int i = 0; i < n; i++) begin
            longint      p;
            logic [63:0] pu;
            p  = longint'($signed(mem[(wb >> 2) + i])) * longint'($signed(mem[(ab >> 2) + i]));
            pu = p;
            acc = acc + pu[47:16];
        end
        if (relu && acc[31]) acc = '0;
        return acc;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] v);
        @(negedge clk);
        s_addr = a[2:0]; s_writedata = v; s_write = 1'b1;
        @(negedge clk);
        s_write = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] v, output int waits);
        @(negedge clk);
        s_addr = a[2:0]; s_read = 1'b1; waits = 0;
        #1;
        while (s_waitrequest && waits < 5000) begin
            @(negedge clk); #1;
            waits++;
        end
        v = s_readdata;
        @(negedge clk);
        s_read = 1'b0;
    endtask

    task automatic launch(input int wb, input int ab, input int n, input bit relu);
        wr(2, wb); wr(3, ab); wr(5, n);
        log_n = 0;
        wr(0, {31'd0, relu});
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        logic [31:0] v; int w;
        rd(0, v, w); chk("R1 result", v, 0); chk("R1 no wait", w, 0);
        rd(2, v, w); chk("R1 wbase", v, 0);
        rd(3, v, w); chk("R1 abase", v, 0);
        rd(5, v, w); chk("R1 len", v, 0);
    endtask

    task automatic t_regs();
        logic [31:0] v; int w;
        wr(2, 32'h0000_0040); wr(3, 32'h0000_0210); wr(5, 32'h0003_0007);
        rd(2, v, w); chk("R2 wbase", v, 32'h0000_0040);
        rd(3, v, w); chk("R2 abase", v, 32'h0000_0210);
        rd(5, v, w); chk("R2 len low bits", v, 32'h0000_0007);
        rd(4, v, w); chk("R2 unused offset", v, 0);
        rd(1, v, w); chk("R2 unused offset", v, 0);
    endtask

    task automatic t_basic();
        logic [31:0] v; int w;
        launch(32'h0, 32'h200, 4, 1'b0);
        rd(0, v, w);
        chk("R4 dot literal", v, 32'h0001_7FFF);
        chk("R5 waited", (w > 0) ? 1 : 0, 1);
        chk("R3 first addr weight", log_addr[0], 32'h0);
        chk("R3 second addr act", log_addr[1], 32'h200);
        chk("R3 third addr w+4", log_addr[2], 32'h4);
        chk("R3 eighth addr a+12", log_addr[7], 32'h20C);
        // second run: accumulator must start from zero
        launch(32'h0, 32'h200, 4, 1'b0);
        rd(0, v, w); chk("R8 cleared at start", v, 32'h0001_7FFF);
    endtask

    task automatic t_relu();
        logic [31:0] v; int w;
        launch(32'h100, 32'h300, 1, 1'b1);
        rd(0, v, w); chk("R6 negative clamped", v, 0);
        launch(32'h100, 32'h300, 1, 1'b0);
        rd(0, v, w); chk("R6 negative passed", v, 32'hFFFD_0000);
        launch(32'h0, 32'h200, 4, 1'b1);
        rd(0, v, w); chk("R6 positive kept", v, 32'h0001_7FFF);
    endtask

    task automatic t_wrap();
        logic [31:0] v; int w;
        launch(32'h080, 32'h280, 2, 1'b0);
        rd(0, v, w); chk("R8 wrap", v, 32'hFFFE_0000);
        launch(32'h080, 32'h280, 2, 1'b1);
        rd(0, v, w); chk("R6 wrapped negative clamped", v, 0);
    endtask

    task automatic t_zero();
        logic [31:0] v; int w;
        launch(32'h0, 32'h200, 0, 1'b0);
        rd(0, v, w); chk("R7 zero length", v, 0);
    endtask

    task automatic t_stall();
        logic [31:0] v; int w;
        stall_cfg = 3; lat_cfg = 5;
        launch(32'h0C0, 32'h2C0, 16, 1'b0);
        rd(0, v, w); chk("R9 stalled dot", v, model(32'h0C0, 32'h2C0, 16, 1'b0));
        stall_cfg = 0; lat_cfg = 1;
    endtask

    task automatic t_busy();
        logic [31:0] v, exp; int w;
        stall_cfg = 2; lat_cfg = 6;
        exp = model(32'h180, 32'h380, 6, 1'b0);
        launch(32'h180, 32'h380, 6, 1'b0);
        repeat (5) @(negedge clk);
        wr(5, 0); wr(2, 32'h0);
        wr(0, 32'h1);
        rd(0, v, w); chk("R10 job unchanged", v, exp);
        rd(5, v, w); chk("R10 len reg updated", v, 0);
        rd(2, v, w); chk("R10 wbase reg updated", v, 0);
        repeat (4) @(negedge clk);
        rd(0, v, w); chk("R11 result held", v, exp);
        chk("R11 no wait", w, 0);
        stall_cfg = 0; lat_cfg = 1;
    endtask

    // ---------------- sequencing ----------------
    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        // basic vectors: weights at 0x000, activations at 0x200
        mem[0] = 32'h0001_0000; mem[128] = 32'h0003_0000;
        mem[1] = 32'h0002_0000; mem[129] = 32'h0000_4000;
        mem[2] = 32'hFFFF_8000; mem[130] = 32'h0004_0000;
        mem[3] = 32'hFFFF_FFFF; mem[131] = 32'h0000_8000;
        // negative single term: -2.0 * 1.5
        mem[64] = 32'hFFFE_0000; mem[192] = 32'h0001_8000;
        // overflow pair at 0x080 / 0x280
        mem[32] = 32'h7FFF_0000; mem[160] = 32'h0001_0000;
        mem[33] = 32'h7FFF_0000; mem[161] = 32'h0001_0000;
        // mixed 16-element vectors at 0x0C0 / 0x2C0
        for (int i = 0; i < 16; i++) begin
            mem[48 + i]  = (i * 32'h0001_3579) ^ ((i % 3 == 0) ? 32'hFFF0_0000 : 32'h0);
            mem[176 + i] = 32'h0000_8000 + i * 32'h0000_2468 - 32'h0001_0000;
        end
        // negative-sum 6-element vectors at 0x180 / 0x380
        for (int i = 0; i < 6; i++) begin
            mem[96 + i]  = 32'hFFFF_0000 - i * 32'h0000_4000;
            mem[224 + i] = 32'h0001_0000 + i * 32'h0000_1000;
        end
        m_readdatavalid = 1'b0;
        m_readdata      = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_basic();
        t_relu();
        t_wrap();
        t_zero();
        t_stall();
        t_busy();
        t_zero();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule